// File: doc/BRIEF.md
# Protected Memory Region Access Filter

This block sits beside a memory controller's request path. It checks every transaction against up to eight programmable address windows. Each window has its own enable. It also has two permission masks, one for reads and one for writes, with one bit for each class of requesting agent. A transaction is described by its byte address, its direction and its agent class. One cycle later the block answers with allow or deny. An address that no enabled window covers passes.

Software configures the windows through a plain synchronous register port. A window can be locked. From then on its configuration is frozen until the next reset. Unlocked windows can be reprogrammed or switched off at any time, for example to remove temporary protection set up during boot. A denied access is treated as fatal. It raises a sticky violation flag and a system reset request, and both stay high until reset.

Top module: `iso_region_filter`

## Requirements
- R1: After reset every window is disabled and unlocked, with base 0, limit 22'h3FFFFF, and read and write masks all ones (7'h7F). violation, reset_req and resp_valid are low.
- R2: cfg_field selects the register of window cfg_sel. The encodings are: 0 = base (bits 21:0), 1 = limit (bits 21:0), 2 = read mask (bits 6:0), 3 = write mask (bits 6:0), 4 = control (bit 0 enable, bit 1 lock). A write with cfg_we high lands on the rising edge. cfg_rdata shows the selected register combinationally. Unused bits and unused field codes read as 0.
- R3: A window matches when it is enabled and base <= txn_addr[31:10] <= limit. Both bounds are inclusive, and address bits 9:0 are ignored.
- R4: A read is checked against the read mask and a write against the write mask. Bit n of a mask is agent code n: 0 flush engine, 1 CPU snoop, 2 CPU management mode, 3 CPU normal mode, 4 resource manager, 5 peripheral channel 0, 6 peripheral channel 1. An agent code with no mask bit is denied wherever a window matches.
- R5: When several windows match, the access is allowed only if every matching window allows it.
- R6: An address covered by no enabled window is allowed. A disabled window has no effect, whatever its masks hold.
- R7: Once a window's lock bit is set, writes to any of its five registers are ignored, including attempts to clear the lock. Only reset unlocks it.
- R8: An unlocked window can be reprogrammed or disabled at any time, and the new setting applies to the next transaction.
- R9: For each cycle with txn_valid high, resp_valid is high on the following cycle with resp_allow carrying the verdict. Without txn_valid, resp_valid is low on the following cycle.
- R10: A denied access sets violation and reset_req on the same edge that presents the deny. Both stay high until reset, and allowed accesses never set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Window index |
| cfg_field | input | 3 | Register select within window |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | 32 | Transaction byte address |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_agent | input | 3 | Agent class code |
| resp_valid | output | 1 | Verdict valid |
| resp_allow | output | 1 | 1 = allowed, 0 = denied |
| violation | output | 1 | Sticky denied-access flag |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The bench probes the first and last 1 KiB page of a window and the pages just outside it. A design with an off-by-one comparison would deny or allow exactly those edge pages wrongly. It places two windows that overlap with different read masks. A filter that consulted only the first hit would allow a transaction that the second window forbids. It tries to rewrite and unlock a locked window and reads the registers back. It then reprograms and disables an unlocked window, which catches a lock that guards too much or too little. Finally it checks that the violation flag survives later allowed traffic and that only reset clears it, together with the locks.

// File: rtl/iso_region_filter.sv
`timescale 1ns/1ps
module iso_region_filter #(
  parameter int NREG   = 8,
  parameter int AW     = 32,
  parameter int GRAN   = 10,
  parameter int NAGENT = 7,
  parameter int DW     = 32,
  localparam int SW    = $clog2(NREG),
  localparam int TW    = $clog2(NAGENT),
  localparam int PW    = AW - GRAN
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [2:0]    cfg_field,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          txn_valid,
  input  logic [AW-1:0] txn_addr,
  input  logic          txn_write,
  input  logic [TW-1:0] txn_agent,
  output logic          resp_valid,
  output logic          resp_allow,
  output logic          violation,
  output logic          reset_req
);
  localparam logic [2:0] F_BASE = 3'd0, F_LIM = 3'd1, F_RD = 3'd2, F_WR = 3'd3, F_CTL = 3'd4;

  logic [PW-1:0]     base_q  [NREG];
  logic [PW-1:0]     lim_q   [NREG];
  logic [NAGENT-1:0] rmask_q [NREG];
  logic [NAGENT-1:0] wmask_q [NREG];
  logic              en_q    [NREG];
  logic              lock_q  [NREG];
  logic [NREG-1:0]   en_vec, lock_vec, block;
  logic [PW-1:0]     page;
  logic [NAGENT-1:0] agent_oh;
  logic              ok;

  assign page     = txn_addr[AW-1:GRAN];
  assign agent_oh = NAGENT'(1) << txn_agent;

  for (genvar i = 0; i < NREG; i++) begin : g_win
    logic hit;
    logic [NAGENT-1:0] perm;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i]  <= '0;
        lim_q[i]   <= '1;
        rmask_q[i] <= '1;
        wmask_q[i] <= '1;
        en_q[i]    <= 1'b0;
        lock_q[i]  <= 1'b0;
      end else if (cfg_we && cfg_sel == SW'(i) && !lock_q[i]) begin
        case (cfg_field)
          F_BASE: base_q[i]  <= cfg_wdata[PW-1:0];
          F_LIM:  lim_q[i]   <= cfg_wdata[PW-1:0];
          F_RD:   rmask_q[i] <= cfg_wdata[NAGENT-1:0];
          F_WR:   wmask_q[i] <= cfg_wdata[NAGENT-1:0];
          F_CTL: begin
            en_q[i]   <= cfg_wdata[0];
            lock_q[i] <= cfg_wdata[1];
          end
          default: ;
        endcase
      end
    end

    assign hit         = en_q[i] && page >= base_q[i] && page <= lim_q[i];
    assign perm        = txn_write ? wmask_q[i] : rmask_q[i];
    assign block[i]    = hit && !(|(perm & agent_oh));
    assign en_vec[i]   = en_q[i];
    assign lock_vec[i] = lock_q[i];
  end

  assign ok = ~|block;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_field)
      F_BASE: cfg_rdata[PW-1:0]     = base_q[cfg_sel];
      F_LIM:  cfg_rdata[PW-1:0]     = lim_q[cfg_sel];
      F_RD:   cfg_rdata[NAGENT-1:0] = rmask_q[cfg_sel];
      F_WR:   cfg_rdata[NAGENT-1:0] = wmask_q[cfg_sel];
      F_CTL:  cfg_rdata[1:0]        = {lock_q[cfg_sel], en_q[cfg_sel]};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      violation  <= 1'b0;
    end else begin
      resp_valid <= txn_valid;
      resp_allow <= txn_valid & ok;
      violation  <= violation | (txn_valid & ~ok);
    end
  end

  assign reset_req = violation;
endmodule

// File: rtl/iso_region_filter_chk.sv
`timescale 1ns/1ps
module iso_region_filter_chk #(
  parameter int NREG = 8
)(
  input logic            clk,
  input logic            rst_n,
  input logic            txn_valid,
  input logic            resp_valid,
  input logic            resp_allow,
  input logic            violation,
  input logic            reset_req,
  input logic [NREG-1:0] en_vec,
  input logic [NREG-1:0] lock_vec
);
  assert_resp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> resp_valid);
  assert_resp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !resp_valid);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);
  assert_deny_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_allow) |-> (violation && reset_req));
  assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation) |-> (resp_valid && !resp_allow));
  assert_lock_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vec & $past(lock_vec)) == $past(lock_vec));
  assert_locked_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_vec ^ $past(en_vec)) & $past(lock_vec)) == '0);
endmodule

bind iso_region_filter iso_region_filter_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .resp_valid(resp_valid),
  .resp_allow(resp_allow), .violation(violation), .reset_req(reset_req),
  .en_vec(en_vec), .lock_vec(lock_vec)
);

// File: tb/sim_iso_region_filter.sv
`timescale 1ns/1ps
module sim_iso_region_filter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cfg_we, txn_valid, txn_write;
  logic [2:0]  cfg_sel, cfg_field, txn_agent;
  logic [31:0] cfg_wdata, cfg_rdata, txn_addr;
  logic        resp_valid, resp_allow, violation, reset_req;

  iso_region_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_write(txn_write),
    .txn_agent(txn_agent), .resp_valid(resp_valid), .resp_allow(resp_allow),
    .violation(violation), .reset_req(reset_req)
  );

  int checks = 0, errors = 0;
  bit exp_q[$];
  string tag_q[$];

  task automatic chk(bit cond, string req, string what, longint act, longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int sel, int fld, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_field = 3'(fld); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(int sel, int fld, logic [31:0] exp, string req);
    cfg_sel = 3'(sel); cfg_field = 3'(fld);
    #1;
    chk(cfg_rdata == exp, req, "readback", cfg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic issue(logic [31:0] a, bit w, int ag, bit exp, string req);
    txn_valid = 1'b1; txn_addr = a; txn_write = w; txn_agent = 3'(ag);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    bit e;
    string t;
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected response", 1, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(resp_allow == e, t, "allow", resp_allow, e);
      end
    end
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_field = 0; cfg_wdata = 0;
    txn_valid = 0; txn_addr = 0; txn_write = 0; txn_agent = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(violation == 0, "R1", "violation", violation, 0);
    chk(reset_req == 0, "R1", "reset_req", reset_req, 0);
    chk(resp_valid == 0, "R1", "resp_valid", resp_valid, 0);
    rd_chk(3, 0, 32'h0, "R1");
    rd_chk(3, 1, 32'h3FFFFF, "R1");
    rd_chk(3, 2, 32'h7F, "R1");
    rd_chk(3, 3, 32'h7F, "R1");
    rd_chk(3, 4, 32'h0, "R1");
    issue(32'h0001_0000, 1, 5, 1, "R6");
    @(negedge clk);

    // R2 window 0: pages 0x40..0x4F, channel-0 writes blocked
    wr(0, 0, 32'hFFC0_0040); wr(0, 1, 32'h4F); wr(0, 3, 32'h5F); wr(0, 4, 32'h1);
    rd_chk(0, 0, 32'h40, "R2");
    rd_chk(0, 1, 32'h4F, "R2");
    rd_chk(0, 3, 32'h5F, "R2");
    rd_chk(0, 4, 32'h1, "R2");
    rd_chk(0, 6, 32'h0, "R2");

    // R3 bounds, back-to-back traffic (R9)
    issue(32'h0001_3FFF, 1, 3, 1, "R3");
    issue(32'h0001_0000, 0, 5, 1, "R4");
    issue(32'h0000_FFFF, 1, 5, 1, "R3");
    issue(32'h0001_4000, 1, 5, 1, "R3");
    issue(32'h0001_0000, 1, 6, 1, "R4");
    @(negedge clk);

    // R5 window 1: pages 0x48..0x60, management-mode reads blocked
    wr(1, 0, 32'h48); wr(1, 1, 32'h60); wr(1, 2, 32'h7B); wr(1, 4, 32'h1);
    issue(32'h0001_1000, 0, 2, 1, "R5");
    issue(32'h0001_2000, 0, 3, 1, "R5");
    issue(32'h0001_2000, 1, 2, 1, "R5");
    @(negedge clk);

    // R6 disabled window with empty masks
    wr(2, 0, 32'h100); wr(2, 1, 32'h100); wr(2, 2, 32'h0); wr(2, 3, 32'h0);
    issue(32'h0004_0000, 1, 0, 1, "R6");
    issue(32'h0004_0200, 0, 6, 1, "R6");
    @(negedge clk);
    chk(violation == 0, "R10", "violation after allowed traffic", violation, 0);

    // R7 lock window 0 and try to change it
    wr(0, 4, 32'h3);
    wr(0, 0, 32'h0); wr(0, 3, 32'h7F); wr(0, 4, 32'h0);
    rd_chk(0, 0, 32'h40, "R7");
    rd_chk(0, 3, 32'h5F, "R7");
    rd_chk(0, 4, 32'h3, "R7");

    // R8 reprogram then disable unlocked window 1
    wr(1, 2, 32'h7F);
    issue(32'h0001_2000, 0, 2, 1, "R8");
    @(negedge clk);
    wr(1, 2, 32'h7B); wr(1, 4, 32'h0);
    issue(32'h0001_2000, 0, 2, 1, "R8");
    @(negedge clk);
    chk(violation == 0, "R10", "violation before deny", violation, 0);

    // R4 / R10 deny
    issue(32'h0001_0000, 1, 5, 0, "R4");
    chk(violation == 1, "R10", "violation after deny", violation, 1);
    chk(reset_req == 1, "R10", "reset_req after deny", reset_req, 1);
    wr(1, 4, 32'h1);
    issue(32'h0001_2000, 0, 2, 0, "R5");
    issue(32'h0001_2000, 0, 7, 0, "R4");
    issue(32'h0005_0000, 0, 0, 1, "R10");
    @(negedge clk);
    chk(violation == 1, "R10", "violation sticky", violation, 1);
    chk(reset_req == 1, "R10", "reset_req sticky", reset_req, 1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "pending responses", exp_q.size(), 0);

    // R7 / R10 reset clears lock and flags
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(violation == 0, "R10", "violation after reset", violation, 0);
    chk(reset_req == 0, "R10", "reset_req after reset", reset_req, 0);
    rd_chk(0, 4, 32'h0, "R7");
    rd_chk(0, 0, 32'h0, "R7");
    wr(0, 0, 32'h22);
    rd_chk(0, 0, 32'h22, "R7");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "pending responses", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule